// File: doc/BRIEF.md
# S/PDIF Receive Error Concealment Unit

This block sits directly behind the biphase decoder of an S/PDIF receiver. For every decoded frame, marked by a one-cycle `frameValid` strobe, it takes the left and right audio words and a set of per-frame condition flags. The flags are parity error, biphase error, validity, lock loss, non-audio, non-PCM sync found, copyright (active low) and a 2-bit rate code. From these it makes one decision per frame for each of its two outputs. The output frame either carries the received words unchanged or is concealed as a whole. Concealment means both words are replaced by zeros or by the last frame that was not concealed.

An 8-bit mask decides what happens to each flag. A masked flag is hidden from software: it does not set the error register and does not raise the interrupt. Instead, on the audio output, a masked parity, biphase or validity condition conceals the frame. An unmasked flag is reported in a sticky error register and by a single-cycle interrupt pulse, and the corrupted data passes through untouched.

A second output feeds a retransmit path. It follows a narrower rule: only a masked validity condition conceals it. Parity and biphase errors never change it. Each output keeps its own hold register.

Top module: `spdif_conceal`

## Requirements
- R1: After reset, `audioL`, `audioR`, `txL`, `txR`, `errReg`, `outValid` and `irqPulse` are all 0. Both hold registers are 0, so a first concealed frame in hold mode outputs zeros.
- R2: A frame sampled with `frameValid`=1 appears on all outputs at the next clock edge, and `outValid` is high for exactly that one cycle. Between frames the data outputs keep their value.
- R3: On the audio output, a frame with `parErr`=1 and mask bit 2 set, or with `bipErr`=1 and mask bit 3 set, has both `audioL` and `audioR` replaced.
- R4: A frame is invalid when `validBit`=1 and `ignoreValid`=0. An invalid frame with mask bit 1 set is replaced on both outputs. When `ignoreValid`=1, the received validity bit has no effect on data, on `errReg` or on the interrupt.
- R5: Replacement data is all zeros when `fillZero`=1. When `fillZero`=0 it is the words of the most recent frame that was not replaced on that output.
- R6: A frame whose only error conditions are unmasked passes through unchanged on both outputs.
- R7: On the retransmit output (`txL`/`txR`), `parErr` and `bipErr` never cause replacement. Only an invalid frame with mask bit 1 set does.
- R8: Error register bit map: 0 lock loss, 1 validity, 2 parity, 3 biphase, 4 non-audio, 5 non-PCM sync, 6 copyright, 7 rate code. In every frame where the condition is present and its mask bit is 0, bits 1, 2 and 3 are set. A bit whose mask bit is 1 is never set by a frame.
- R9: Bits 0, 4, 5 and 7 are set when `lockLost`, `nonAudio`, `nonPcm` or `freqMode` differ from their values in the previous frame. Bit 6 is set when `copyN` goes from 1 in the previous frame to 0. The previous values after reset are 0, 0, 0, 2'b00 and `copyN`=1. `freqMode` is 00 for unsupported, 01 for 88-96 kHz, 10 for 44-48 kHz and 11 for 32 kHz. Any change of this code is an event.
- R10: `errReg` bits are sticky until an `errClear` strobe clears them at the next edge. An unmasked event in a frame sampled in the same cycle as the clear is still recorded.
- R11: `irqPulse` is high for exactly the one cycle after `frameValid` when that frame produced at least one unmasked event. Otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frameValid | input | 1 | One-cycle strobe: a decoded frame is present |
| leftIn | input | SAMPLE_W | Left sub-frame audio word |
| rightIn | input | SAMPLE_W | Right sub-frame audio word |
| parErr | input | 1 | Parity error in either sub-frame |
| bipErr | input | 1 | Biphase coding error in either sub-frame |
| validBit | input | 1 | Received validity bit (1 = invalid) |
| lockLost | input | 1 | Receiver not locked |
| nonAudio | input | 1 | Channel status marks data as non-audio |
| nonPcm | input | 1 | Compressed-data sync word found |
| copyN | input | 1 | Copyright, active low |
| freqMode | input | 2 | Received rate code |
| flagMask | input | 8 | Per-flag mask, 1 = masked |
| fillZero | input | 1 | 1 = conceal with zeros, 0 = hold last good frame |
| ignoreValid | input | 1 | 1 = disregard the received validity bit |
| errClear | input | 1 | One-cycle clear of the error register |
| audioL | output | SAMPLE_W | Audio path left word |
| audioR | output | SAMPLE_W | Audio path right word |
| txL | output | SAMPLE_W | Retransmit path left word |
| txR | output | SAMPLE_W | Retransmit path right word |
| outValid | output | 1 | Outputs updated this cycle |
| errReg | output | 8 | Sticky error register |
| irqPulse | output | 1 | One-cycle interrupt pulse |

## Verification
The embedded properties watch these rules on every cycle:
- the interrupt appears only in the cycle after a frame strobe;
- error bits stay set unless cleared;
- a masked flag never sets a new bit;
- a clear with no frame empties the register;
- each output path passes its input, outputs zeros or holds its last good frame, as its replace decision requires.

Other outcomes depend on history across frames, and only the bench's sweeps can show them:
- the exact mapping of each flag to its error bit;
- that the retransmit path ignores parity and biphase errors;
- the change detection on the status flags, including the falling-edge rule for copyright;
- that the hold registers follow only unreplaced frames.

// File: rtl/spdif_conceal_pkg.sv
package spdif_conceal_pkg;

  localparam int NUM_FLAGS = 8;

  // Error register / mask bit positions
  localparam int FLAG_LOCK  = 0;
  localparam int FLAG_VALID = 1;
  localparam int FLAG_PAR   = 2;
  localparam int FLAG_BIP   = 3;
  localparam int FLAG_NAUD  = 4;
  localparam int FLAG_NPCM  = 5;
  localparam int FLAG_COPY  = 6;
  localparam int FLAG_FREQ  = 7;

  localparam int FREQ_W = 2;

  typedef struct packed {
    logic load;       // a frame is being committed this cycle
    logic replAudio;  // conceal the audio path
    logic replTx;     // conceal the retransmit path
    logic fillZero;   // concealment source select
  } ctrlStrobes_t;

endpackage

// File: rtl/spdif_conceal_ctrl.sv
module spdif_conceal_ctrl
  import spdif_conceal_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frameValid,
  input  logic                 parErr,
  input  logic                 bipErr,
  input  logic                 validBit,
  input  logic                 lockLost,
  input  logic                 nonAudio,
  input  logic                 nonPcm,
  input  logic                 copyN,
  input  logic [FREQ_W-1:0]    freqMode,
  input  logic [NUM_FLAGS-1:0] flagMask,
  input  logic                 fillZero,
  input  logic                 ignoreValid,
  input  logic                 errClear,
  output ctrlStrobes_t         strobes,
  output logic                 outValid,
  output logic [NUM_FLAGS-1:0] errReg,
  output logic                 irqPulse
);

  // Previous-frame status, used for change detection
  logic              prevLock;
  logic              prevNaud;
  logic              prevNpcm;
  logic              prevCopyN;
  logic [FREQ_W-1:0] prevFreq;

  logic                 frameInvalid;
  logic [NUM_FLAGS-1:0] rawEvents;
  logic [NUM_FLAGS-1:0] liveEvents;

  always_comb begin
    frameInvalid = validBit && !ignoreValid;
    rawEvents                = '0;
    rawEvents[FLAG_LOCK]     = lockLost != prevLock;
    rawEvents[FLAG_VALID]    = frameInvalid;
    rawEvents[FLAG_PAR]      = parErr;
    rawEvents[FLAG_BIP]      = bipErr;
    rawEvents[FLAG_NAUD]     = nonAudio != prevNaud;
    rawEvents[FLAG_NPCM]     = nonPcm != prevNpcm;
    rawEvents[FLAG_COPY]     = prevCopyN && !copyN;
    rawEvents[FLAG_FREQ]     = freqMode != prevFreq;
    liveEvents = frameValid ? (rawEvents & ~flagMask) : '0;
  end

  always_comb begin
    strobes.load      = frameValid;
    strobes.fillZero  = fillZero;
    strobes.replAudio = (parErr && flagMask[FLAG_PAR])
                     || (bipErr && flagMask[FLAG_BIP])
                     || (frameInvalid && flagMask[FLAG_VALID]);
    strobes.replTx    = frameInvalid && flagMask[FLAG_VALID];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevLock  <= 1'b0;
      prevNaud  <= 1'b0;
      prevNpcm  <= 1'b0;
      prevCopyN <= 1'b1;
      prevFreq  <= '0;
    end else if (frameValid) begin
      prevLock  <= lockLost;
      prevNaud  <= nonAudio;
      prevNpcm  <= nonPcm;
      prevCopyN <= copyN;
      prevFreq  <= freqMode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      errReg   <= '0;
      irqPulse <= 1'b0;
      outValid <= 1'b0;
    end else begin
      errReg   <= (errClear ? '0 : errReg) | liveEvents;
      irqPulse <= |liveEvents;
      outValid <= frameValid;
    end
  end

  // R11: the interrupt only follows a frame strobe
  assert_irq_after_frame_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irqPulse |-> $past(frameValid));

  // R10: without a clear, no set bit drops
  assert_sticky_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !errClear |=> ((errReg & $past(errReg)) == $past(errReg)));

  // R10: a clear with no frame empties the register
  assert_clear_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (errClear && !frameValid) |=> (errReg == '0));

  // R8: a masked flag never sets a new bit
  assert_masked_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !errClear |=> ((errReg & ~$past(errReg) & $past(flagMask)) == '0));

endmodule

// File: rtl/spdif_conceal_path.sv
module spdif_conceal_path
  import spdif_conceal_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                repl,
  input  logic                fillZero,
  input  logic [SAMPLE_W-1:0] inL,
  input  logic [SAMPLE_W-1:0] inR,
  output logic [SAMPLE_W-1:0] outL,
  output logic [SAMPLE_W-1:0] outR
);

  localparam logic [SAMPLE_W-1:0] ZERO_WORD = '0;

  logic [SAMPLE_W-1:0] holdL;
  logic [SAMPLE_W-1:0] holdR;
  logic [SAMPLE_W-1:0] fillL;
  logic [SAMPLE_W-1:0] fillR;

  always_comb begin
    fillL = fillZero ? ZERO_WORD : holdL;
    fillR = fillZero ? ZERO_WORD : holdR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      holdL <= '0;
      holdR <= '0;
      outL  <= '0;
      outR  <= '0;
    end else if (load) begin
      if (repl) begin
        outL <= fillL;
        outR <= fillR;
      end else begin
        outL  <= inL;
        outR  <= inR;
        holdL <= inL;
        holdR <= inR;
      end
    end
  end

  // R6: an unreplaced frame passes unchanged
  assert_pass_through_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !repl) |=> (outL == $past(inL) && outR == $past(inR)));

  // R5: zero fill gives zero words
  assert_zero_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && repl && fillZero) |=> (outL == ZERO_WORD && outR == ZERO_WORD));

  // R5: hold fill repeats the last unreplaced output
  assert_hold_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && repl && !fillZero) |=> (outL == holdL && outR == holdR && $stable(holdL)));

  // R2: outputs keep their value between frames
  assert_stable_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(outL) && $stable(outR)));

endmodule

// File: rtl/spdif_conceal.sv
module spdif_conceal
  import spdif_conceal_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frameValid,
  input  logic [SAMPLE_W-1:0]  leftIn,
  input  logic [SAMPLE_W-1:0]  rightIn,
  input  logic                 parErr,
  input  logic                 bipErr,
  input  logic                 validBit,
  input  logic                 lockLost,
  input  logic                 nonAudio,
  input  logic                 nonPcm,
  input  logic                 copyN,
  input  logic [1:0]           freqMode,
  input  logic [7:0]           flagMask,
  input  logic                 fillZero,
  input  logic                 ignoreValid,
  input  logic                 errClear,
  output logic [SAMPLE_W-1:0]  audioL,
  output logic [SAMPLE_W-1:0]  audioR,
  output logic [SAMPLE_W-1:0]  txL,
  output logic [SAMPLE_W-1:0]  txR,
  output logic                 outValid,
  output logic [7:0]           errReg,
  output logic                 irqPulse
);

  ctrlStrobes_t strobes;

  spdif_conceal_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .frameValid  (frameValid),
    .parErr      (parErr),
    .bipErr      (bipErr),
    .validBit    (validBit),
    .lockLost    (lockLost),
    .nonAudio    (nonAudio),
    .nonPcm      (nonPcm),
    .copyN       (copyN),
    .freqMode    (freqMode),
    .flagMask    (flagMask),
    .fillZero    (fillZero),
    .ignoreValid (ignoreValid),
    .errClear    (errClear),
    .strobes     (strobes),
    .outValid    (outValid),
    .errReg      (errReg),
    .irqPulse    (irqPulse)
  );

  spdif_conceal_path #(.SAMPLE_W(SAMPLE_W)) u_audioPath (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (strobes.load),
    .repl     (strobes.replAudio),
    .fillZero (strobes.fillZero),
    .inL      (leftIn),
    .inR      (rightIn),
    .outL     (audioL),
    .outR     (audioR)
  );

  spdif_conceal_path #(.SAMPLE_W(SAMPLE_W)) u_txPath (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (strobes.load),
    .repl     (strobes.replTx),
    .fillZero (strobes.fillZero),
    .inL      (leftIn),
    .inR      (rightIn),
    .outL     (txL),
    .outR     (txR)
  );

  // R2: the output strobe is one cycle wide
  assert_valid_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> $past(frameValid));

endmodule

// File: tb/spdif_conceal_bench.sv
`timescale 1ns/1ps
module spdif_conceal_bench;

  localparam int W = 24;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         frameValid = 1'b0;
  logic [W-1:0] leftIn = '0;
  logic [W-1:0] rightIn = '0;
  logic         parErr = 1'b0, bipErr = 1'b0, validBit = 1'b0;
  logic         lockLost = 1'b0, nonAudio = 1'b0, nonPcm = 1'b0, copyN = 1'b1;
  logic [1:0]   freqMode = 2'b00;
  logic [7:0]   flagMask = '0;
  logic         fillZero = 1'b0, ignoreValid = 1'b0, errClear = 1'b0;
  logic [W-1:0] audioL, audioR, txL, txR;
  logic         outValid, irqPulse;
  logic [7:0]   errReg;

  int checks = 0;
  int fails = 0;

  // Reference state
  logic [W-1:0] mHoldL = '0, mHoldR = '0, mTxHoldL = '0, mTxHoldR = '0;
  logic [W-1:0] mAudL = '0, mAudR = '0, mTxL = '0, mTxR = '0;
  logic [7:0]   mErr = '0;
  logic         mIrq = 1'b0;
  logic         pLock = 0, pNaud = 0, pNpcm = 0, pCopyN = 1;
  logic [1:0]   pFreq = 2'b00;
  int           frameNo = 0;

  always #2.5 clk = ~clk;

  spdif_conceal u_spdif_conceal (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (frame %0d)", req, act, exp, frameNo);
    end
  endtask

  // Drive one frame, model it, compare all outputs one cycle later
  task automatic doFrame(input logic par, input logic bip, input logic vb,
                         input logic lk, input logic na, input logic np,
                         input logic cp, input logic [1:0] fm, input logic clr);
    logic [7:0] ev;
    logic inv, replA, replT;
    logic [W-1:0] l, r;
    frameNo++;
    l = W'(32'h0A0000 + frameNo * 7);
    r = W'(32'h050000 + frameNo * 13);
    @(negedge clk);
    frameValid = 1'b1; leftIn = l; rightIn = r;
    parErr = par; bipErr = bip; validBit = vb;
    lockLost = lk; nonAudio = na; nonPcm = np; copyN = cp; freqMode = fm;
    errClear = clr;
    inv = vb & ~ignoreValid;
    ev = '0;
    ev[0] = lk != pLock; ev[1] = inv; ev[2] = par; ev[3] = bip;
    ev[4] = na != pNaud; ev[5] = np != pNpcm; ev[6] = pCopyN & ~cp;
    ev[7] = fm != pFreq;
    ev = ev & ~flagMask;
    replA = (par & flagMask[2]) | (bip & flagMask[3]) | (inv & flagMask[1]);
    replT = inv & flagMask[1];
    if (replA) begin
      mAudL = fillZero ? '0 : mHoldL; mAudR = fillZero ? '0 : mHoldR;
    end else begin
      mAudL = l; mAudR = r; mHoldL = l; mHoldR = r;
    end
    if (replT) begin
      mTxL = fillZero ? '0 : mTxHoldL; mTxR = fillZero ? '0 : mTxHoldR;
    end else begin
      mTxL = l; mTxR = r; mTxHoldL = l; mTxHoldR = r;
    end
    mErr = (clr ? 8'h00 : mErr) | ev;
    mIrq = |ev;
    pLock = lk; pNaud = na; pNpcm = np; pCopyN = cp; pFreq = fm;
    @(negedge clk);
    frameValid = 1'b0; errClear = 1'b0;
    check("R3/R4/R5/R6 audioL", 32'(audioL), 32'(mAudL));
    check("R3/R4/R5/R6 audioR", 32'(audioR), 32'(mAudR));
    check("R7 txL", 32'(txL), 32'(mTxL));
    check("R7 txR", 32'(txR), 32'(mTxR));
    check("R8/R9/R10 errReg", 32'(errReg), 32'(mErr));
    check("R11 irqPulse", 32'(irqPulse), 32'(mIrq));
    check("R2 outValid high", 32'(outValid), 32'd1);
    @(negedge clk);
    check("R2 outValid one cycle", 32'(outValid), 32'd0);
    check("R11 irq one cycle", 32'(irqPulse), 32'd0);
    check("R2 audioL held", 32'(audioL), 32'(mAudL));
  endtask

  task automatic clearErr();
    @(negedge clk); errClear = 1'b1;
    @(negedge clk); errClear = 1'b0; mErr = '0;
    check("R10 clear strobe", 32'(errReg), 32'd0);
  endtask

  initial begin : watchdog
    #(5ns * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 audioL", 32'(audioL), 0);
    check("R1 txR", 32'(txR), 0);
    check("R1 errReg", 32'(errReg), 0);
    check("R1 irq", 32'(irqPulse), 0);
    check("R1 outValid", 32'(outValid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1/R5: concealed first frame in hold mode gives zeros
    flagMask = 8'h04; fillZero = 1'b0;
    doFrame(1, 0, 0, 0, 0, 0, 1, 2'b00, 0);
    check("R1 hold zero after reset", 32'(audioL), 0);

    // Sweep: data-error masks x fill x override x error pattern
    for (int m = 0; m < 8; m++) begin
      for (int f = 0; f < 4; f++) begin
        for (int e = 0; e < 8; e++) begin
          flagMask = {4'b0000, m[2:0], 1'b0};
          fillZero = f[0]; ignoreValid = f[1];
          doFrame(e[0], e[1], e[2], 0, 0, 0, 1, 2'b00, 0);
          doFrame(0, 0, 0, 0, 0, 0, 1, 2'b00, 0);
        end
        clearErr();
      end
    end

    // Sweep: status flag changes under several masks (R9)
    for (int m = 0; m < 4; m++) begin
      flagMask = (m == 0) ? 8'h00 : (m == 1) ? 8'hF1 : (m == 2) ? 8'h50 : 8'hA1;
      fillZero = 1'b0; ignoreValid = 1'b0;
      for (int s = 0; s < 64; s++) begin
        doFrame(0, 0, 0, s[0], s[1], s[2], s[3], s[5:4], 0);
        if (s % 8 == 7) clearErr();
      end
    end

    // R10: clear in the same cycle as an unmasked event keeps the event
    flagMask = 8'h00;
    doFrame(1, 0, 0, 0, 0, 0, 1, 2'b00, 0);
    doFrame(0, 1, 0, 0, 0, 0, 1, 2'b00, 1);
    check("R10 event kept over clear", 32'(errReg), 32'h08);

    // R4: override hides validity entirely
    clearErr();
    flagMask = 8'h02; ignoreValid = 1'b1;
    doFrame(0, 0, 1, 0, 0, 0, 1, 2'b00, 0);
    check("R4 override passes data", 32'(txL), 32'(leftIn));
    ignoreValid = 1'b0; flagMask = 8'h00;
    doFrame(0, 0, 1, 0, 0, 0, 1, 2'b00, 0);
    check("R4/R6 unmasked invalid flagged", 32'(errReg), 32'h02);

    // R7: masked parity and biphase leave retransmit untouched
    flagMask = 8'h0C; fillZero = 1'b1;
    doFrame(1, 1, 0, 0, 0, 0, 1, 2'b00, 0);
    check("R7 tx passes on parity", 32'(txR), 32'(rightIn));
    check("R3 audio zeroed", 32'(audioR), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule